// File: doc/BRIEF.md
# Flash-to-RAM overlay address remapper

This block lets part of an on-chip RAM take the place of a small low region of flash. Parameters held in that region can then be tuned while the system runs, with no erase or program cycle. A control byte picks one of four overlay modes from two select bits. Each CPU access with a 16-bit address goes to one of three targets: the control byte, the overlay RAM, or flash. The RAM can always be reached at its own range, 0xF800 to 0xF97F. While an overlay is active, the same RAM cells can also be reached through the low flash addresses that the overlay covers.

The overlay mode is the block's only state. It comes from bits 7 and 6 of the control byte. The four modes are:

- OVL_OFF (code 00): no overlay.
- OVL_MID (code 01): 0x0080 to 0x00FF maps to 0xF880.
- OVL_WIDE (code 10): 0x0080 to 0x017F maps to 0xF880.
- OVL_LOW (code 11): 0x0000 to 0x007F maps to 0xF800.

The mode changes in three ways. A register write moves it to the mode its bits 7:6 select. Reset forces OVL_OFF. Hardware standby also forces OVL_OFF. Software standby causes no transition.

The actual flash array is outside the block. It returns read data on an input, and the block asserts a flash read strobe for reads that flash must serve. Nothing is ever written to flash through this block.

Top module: `ovl_remap`

## Requirements
- R1: An active-low reset, or a cycle with hw_stby high, sets the control byte to 0x08 (bit 3 set, all others clear). In this state the mode is OVL_OFF.
- R2: Asserting sw_stby leaves the control byte unchanged.
- R3: With reg_sel high, cpu_wr writes the control byte on the clock edge and cpu_rd returns it on cpu_rdata. Bit 4 is reserved: it always reads 0 and writes to it are ignored.
- R4: With bits 7:6 = 00, every address below 0xF800 and above 0xF97F is read from flash.
- R5: With bits 7:6 = 01, addresses 0x0080 to 0x00FF read RAM cells 0xF880 to 0xF8FF. 0x007F and 0x0100 read flash.
- R6: With bits 7:6 = 10, addresses 0x0080 to 0x017F read RAM cells 0xF880 to 0xF97F. 0x007F and 0x0180 read flash.
- R7: With bits 7:6 = 11, addresses 0x0000 to 0x007F read RAM cells 0xF800 to 0xF87F. 0x0080 reads flash.
- R8: Addresses 0xF800 to 0xF97F always reach RAM, in every mode. A write through an overlaid flash address can be read back at the RAM address, and the reverse also holds. 0xF7FF and 0xF980 read flash.
- R9: A write to an address that maps to flash changes no RAM cell.
- R10: flash_rd is high exactly when cpu_rd is high, reg_sel is low and the address maps to flash. Read data is combinational on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby; reinitialises the control byte |
| sw_stby | input | 1 | Software standby; control byte keeps its value |
| reg_sel | input | 1 | Steers the bus access to the control byte |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (combinational) |
| flash_rd | output | 1 | Read request to flash |
| flash_rdata | input | 8 | Data returned by flash |

## Verification
A wrong overlay mode shows at the ports on the first read after the register write. The read returns flash data where RAM data was expected, or the reverse, and flash_rd flips with it. An error in the offset arithmetic shows as a RAM value taken from the wrong cell. It appears at once when a window is probed at its first and last address. A lost or spurious clear of the control byte shows on the next register read.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] CTRL_RST   = 8'h08;
    localparam logic [DATA_W-1:0] CTRL_WMASK = 8'hEF;

    typedef enum logic [1:0] {
        OVL_OFF  = 2'b00,
        OVL_MID  = 2'b01,
        OVL_WIDE = 2'b10,
        OVL_LOW  = 2'b11
    } ovl_mode_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        logic [ADDR_W-1:0] ram_at;
    } ovl_win_t;

    function automatic ovl_win_t win_of(ovl_mode_e m);
        ovl_win_t w;
        w = '0;
        unique case (m)
            OVL_OFF:  w = '0;
            OVL_MID:  w = '{en: 1'b1, lo: 16'h0080, hi: 16'h00FF, ram_at: 16'hF880};
            OVL_WIDE: w = '{en: 1'b1, lo: 16'h0080, hi: 16'h017F, ram_at: 16'hF880};
            OVL_LOW:  w = '{en: 1'b1, lo: 16'h0000, hi: 16'h007F, ram_at: 16'hF800};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg
    import ovl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output ovl_mode_e         mode
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (hw_stby) begin
            ctrl_q <= CTRL_RST;
        end else if (wr_en) begin
            ctrl_q <= wdata & CTRL_WMASK;
        end
    end

    always_comb begin
        mode = ovl_mode_e'(ctrl_q[DATA_W-1 -: 2]);
    end

endmodule

// File: rtl/ovl_decode.sv
module ovl_decode
    import ovl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_BASE  = 16'hF800,
    parameter int                RAM_WORDS = 384,
    localparam int               IDX_W     = $clog2(RAM_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    input  ovl_mode_e         mode,
    output logic              hit_ram,
    output logic [IDX_W-1:0]  ram_idx
);

    localparam logic [ADDR_W-1:0] RAM_LAST = RAM_BASE + ADDR_W'(RAM_WORDS - 1);

    ovl_win_t win;
    logic     in_own;
    logic     in_win;

    always_comb begin
        win    = win_of(mode);
        in_own = (addr >= RAM_BASE) && (addr <= RAM_LAST);
        in_win = win.en && (addr >= win.lo) && (addr <= win.hi);
        if (in_own) begin
            ram_idx = IDX_W'(addr - RAM_BASE);
        end else if (in_win) begin
            ram_idx = IDX_W'((win.ram_at - RAM_BASE) + (addr - win.lo));
        end else begin
            ram_idx = '0;
        end
        hit_ram = in_own || in_win;
    end

endmodule

// File: rtl/ovl_ram.sv
module ovl_ram
    import ovl_pkg::*;
#(
    parameter int  WORDS = 384,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/ovl_remap.sv
module ovl_remap
    import ovl_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RAM_BASE  = 16'hF800,
    parameter int                RAM_WORDS = 384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              flash_rd,
    input  logic [DATA_W-1:0] flash_rdata
);

    localparam int IDX_W = $clog2(RAM_WORDS);

    logic [DATA_W-1:0] ctrl_q;
    ovl_mode_e         mode;
    logic              hit_ram;
    logic [IDX_W-1:0]  ram_idx;
    logic [DATA_W-1:0] ram_rdata;
    logic              ram_we;

    ovl_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_stby(hw_stby),
        .wr_en  (reg_sel && cpu_wr),
        .wdata  (cpu_wdata),
        .ctrl_q (ctrl_q),
        .mode   (mode)
    );

    ovl_decode #(.RAM_BASE(RAM_BASE), .RAM_WORDS(RAM_WORDS)) u_dec (
        .addr   (cpu_addr),
        .mode   (mode),
        .hit_ram(hit_ram),
        .ram_idx(ram_idx)
    );

    assign ram_we = cpu_wr && !reg_sel && hit_ram;

    ovl_ram #(.WORDS(RAM_WORDS)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .idx  (ram_idx),
        .wdata(cpu_wdata),
        .rdata(ram_rdata)
    );

    always_comb begin
        flash_rd = cpu_rd && !reg_sel && !hit_ram;
        if (reg_sel) begin
            cpu_rdata = ctrl_q;
        end else if (hit_ram) begin
            cpu_rdata = ram_rdata;
        end else begin
            cpu_rdata = flash_rdata;
        end
    end

endmodule

// File: rtl/ovl_remap_chk.sv
module ovl_remap_chk
    import ovl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              hw_stby,
    input logic              sw_stby,
    input logic              reg_sel,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              flash_rd,
    input logic [DATA_W-1:0] ctrl_q
);

    a_r1_hw_stby_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> (ctrl_q == 8'h08));

    a_r2_sw_stby_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_stby && !hw_stby && !(reg_sel && cpu_wr)) |=> $stable(ctrl_q));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[4] == 1'b0);

    a_r4_off_goes_flash: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7:6] == 2'b00 && cpu_rd && !reg_sel && cpu_addr < 16'hF800) |-> flash_rd);

    a_r8_own_range_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 16'hF800 && cpu_addr <= 16'hF97F) |-> !flash_rd);

    a_r10_reg_no_flash: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel || !cpu_rd) |-> !flash_rd);

endmodule

bind ovl_remap ovl_remap_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_stby (hw_stby),
    .sw_stby (sw_stby),
    .reg_sel (reg_sel),
    .cpu_rd  (cpu_rd),
    .cpu_wr  (cpu_wr),
    .cpu_addr(cpu_addr),
    .flash_rd(flash_rd),
    .ctrl_q  (ctrl_q)
);

// File: tb/tb_ovl_remap.sv
`timescale 1ns/1ps
module tb_ovl_remap;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_stby = 1'b0;
    logic        sw_stby = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        flash_rd;
    logic [7:0]  flash_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] fpat(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h96;
    endfunction

    function automatic logic [7:0] rpat(int i);
        return 8'((i * 7 + 3) ^ (i >> 4));
    endfunction

    assign flash_rdata = fpat(cpu_addr);

    ovl_remap dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_stby    (hw_stby),
        .sw_stby    (sw_stby),
        .reg_sel    (reg_sel),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .flash_rd   (flash_rd),
        .flash_rdata(flash_rdata)
    );

    // {mode[1:0], expect_ram, ram_idx[8:0], addr[15:0]}
    localparam int NV = 21;
    localparam logic [27:0] VEC [NV] = '{
        {2'b00, 1'b0, 9'h000, 16'h0000},
        {2'b00, 1'b0, 9'h000, 16'h0080},
        {2'b00, 1'b0, 9'h000, 16'h017F},
        {2'b01, 1'b1, 9'h080, 16'h0080},
        {2'b01, 1'b1, 9'h0FF, 16'h00FF},
        {2'b01, 1'b0, 9'h000, 16'h007F},
        {2'b01, 1'b0, 9'h000, 16'h0100},
        {2'b10, 1'b1, 9'h080, 16'h0080},
        {2'b10, 1'b1, 9'h17F, 16'h017F},
        {2'b10, 1'b0, 9'h000, 16'h007F},
        {2'b10, 1'b0, 9'h000, 16'h0180},
        {2'b11, 1'b1, 9'h000, 16'h0000},
        {2'b11, 1'b1, 9'h07F, 16'h007F},
        {2'b11, 1'b0, 9'h000, 16'h0080},
        {2'b00, 1'b1, 9'h000, 16'hF800},
        {2'b00, 1'b1, 9'h17F, 16'hF97F},
        {2'b00, 1'b0, 9'h000, 16'hF7FF},
        {2'b00, 1'b0, 9'h000, 16'hF980},
        {2'b11, 1'b1, 9'h080, 16'hF880},
        {2'b01, 1'b1, 9'h100, 16'hF900},
        {2'b10, 1'b1, 9'h000, 16'hF800}
    };

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic reg_write(logic [7:0] v);
        @(negedge clk);
        reg_sel = 1'b1; cpu_wr = 1'b1; cpu_wdata = v;
        @(negedge clk);
        reg_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic bus_write(logic [15:0] a, logic [7:0] v);
        @(negedge clk);
        cpu_addr = a; cpu_wr = 1'b1; cpu_wdata = v;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic bus_read(logic [15:0] a, output logic [7:0] d, output logic fr);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
        d = cpu_rdata; fr = flash_rd;
        cpu_rd = 1'b0;
    endtask

    task automatic reg_read(output logic [7:0] d, output logic fr);
        @(negedge clk);
        reg_sel = 1'b1; cpu_rd = 1'b1;
        #1;
        d = cpu_rdata; fr = flash_rd;
        reg_sel = 1'b0; cpu_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       fr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        reg_read(d, fr);
        check("R1 reset value", d, 8'h08);
        check("R10 no flash_rd on reg read", {7'b0, fr}, 8'h00);

        for (int i = 0; i < 384; i++) bus_write(16'hF800 + 16'(i), rpat(i));

        for (int k = 0; k < NV; k++) begin
            logic [27:0] e;
            logic [7:0]  exp;
            string       tag;
            e = VEC[k];
            if (e[15:0] >= 16'hF000) tag = "R8";
            else case (e[27:26])
                2'b00: tag = "R4";
                2'b01: tag = "R5";
                2'b10: tag = "R6";
                default: tag = "R7";
            endcase
            reg_write({e[27:26], 6'b001000});
            exp = e[25] ? rpat(int'(e[24:16])) : fpat(e[15:0]);
            bus_read(e[15:0], d, fr);
            check($sformatf("%s data @%04h", tag, e[15:0]), d, exp);
            check($sformatf("R10 flash_rd @%04h", e[15:0]), {7'b0, fr}, {7'b0, !e[25]});
        end

        // R8 aliasing both directions
        reg_write(8'hC8);
        bus_write(16'h0005, 8'h5A);
        bus_read(16'hF805, d, fr);
        check("R8 alias flash->ram", d, 8'h5A);
        bus_write(16'hF806, 8'h33);
        bus_read(16'h0006, d, fr);
        check("R8 alias ram->flash", d, 8'h33);
        reg_write(8'h88);
        bus_write(16'h017F, 8'hC3);
        bus_read(16'hF97F, d, fr);
        check("R8 alias wide last", d, 8'hC3);

        // R9 writes to flash-mapped addresses reach no RAM cell
        reg_write(8'h08);
        bus_write(16'h0080, 8'hEE);
        bus_read(16'hF880, d, fr);
        check("R9 off-mode write", d, rpat(16'h080));
        reg_write(8'h48);
        bus_write(16'h0100, 8'hEE);
        bus_read(16'hF900, d, fr);
        check("R9 outside window write", d, rpat(16'h100));

        // R3 register and reserved bit
        reg_write(8'hFF);
        reg_read(d, fr);
        check("R3 reserved bit ignored", d, 8'hEF);

        // R2 software standby keeps contents
        @(negedge clk); sw_stby = 1'b1;
        repeat (3) @(negedge clk); sw_stby = 1'b0;
        reg_read(d, fr);
        check("R2 sw standby hold", d, 8'hEF);

        // R1 hardware standby clears
        @(negedge clk); hw_stby = 1'b1;
        @(negedge clk); hw_stby = 1'b0;
        reg_read(d, fr);
        check("R1 hw standby clear", d, 8'h08);
        bus_read(16'h0000, d, fr);
        check("R1 mode off after hw standby", d, fpat(16'h0000));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule